// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit with HI/LO Result Registers

This unit performs 32-bit multiplication and division over many cycles. It keeps its results in two dedicated registers, HI and LO, and does not return them to a destination register. A pipeline issues a start command with an operation code and two operands, then carries on with other work. Later it retrieves the results through a read port that selects HI or LO.

A write port loads HI or LO directly, so software can save and restore them. The `busy` output marks an operation in flight. A read or write request made while busy raises `stall`, which the pipeline uses to wait. Both multiply and divide process one operand bit per cycle, so every operation takes 32 cycles. Neither operation ever signals an overflow.

Top module: `mdu_top`

## Requirements
- R1: After reset, `busy` and `stall` are 0 and both HI and LO read back as 0.
- R2: A start with `startOp`=0 (signed multiply) leaves the upper 32 bits of the 64-bit two's-complement product in HI and the lower 32 bits in LO.
- R3: A start with `startOp`=1 (unsigned multiply) leaves the upper half of the 64-bit unsigned product in HI and the lower half in LO.
- R4: A start with `startOp`=2 (signed divide) leaves the quotient in LO, truncated toward zero, and the remainder in HI, carrying the sign of the dividend. The case 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0 with no error indication.
- R5: A start with `startOp`=3 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R6: A start accepted while idle raises `busy` from the next cycle. `busy` then stays high for exactly 32 cycles, and the results are readable in the first cycle in which `busy` is low.
- R7: A start presented while `busy` is high is ignored: the running operation's result and timing are unchanged.
- R8: `rdData` shows HI when `rdSelHi`=1 and LO when `rdSelHi`=0, in the same cycle. `stall` is 1 when `rdReq` is high during `busy` and 0 when the unit is idle.
- R9: `wrEn` while idle loads `wrData` into HI (`wrSelHi`=1) or LO (`wrSelHi`=0) at the next clock edge. `wrEn` while busy raises `stall` and leaves HI and LO unchanged.
- R10: A divide by zero, signed or unsigned, still drops `busy` after exactly 32 cycles. The result values are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start command strobe |
| startOp | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| rdReq | input | 1 | Move-from request (used for stall) |
| rdSelHi | input | 1 | Read select: 1 HI, 0 LO |
| rdData | output | 32 | Selected result register |
| stall | output | 1 | Read or write must wait |
| wrEn | input | 1 | Move-to request |
| wrSelHi | input | 1 | Write select: 1 HI, 0 LO |
| wrData | input | 32 | Value for move-to |

## Verification
A start sampled at one rising edge shows `busy` at the following falling edge. `busy` stays high at 32 consecutive falling edges and is low at the 33rd, and HI/LO are read only from that point onward. The bench drives every input at a falling edge and reads the combinational `rdData` one time step after changing the select, so each comparison lands in the cycle the result is due. Move-to writes are checked one edge after they are driven. Probes during a run, for stall and for an ignored write or start, are placed at fixed cycle offsets inside the 32-cycle window.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MULS = 2'd0,
    OP_MULU = 2'd1,
    OP_DIVS = 2'd2,
    OP_DIVU = 2'd3
  } mdu_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    step;
    logic    finish;
    logic    wrHi;
    logic    wrLo;
    mdu_op_e op;
  } mdu_strobe_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [1:0]  startOp,
  input  logic        rdReq,
  input  logic        wrEn,
  input  logic        wrSelHi,
  output logic        busy,
  output logic        stall,
  output mdu_strobe_t strb
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic             running;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      count   <= '0;
    end else if (!running && startValid) begin
      running <= 1'b1;
      count   <= '0;
    end else if (running) begin
      if (count == LAST) running <= 1'b0;
      count <= count + 1'b1;
    end
  end

  assign busy  = running;
  assign stall = running & (rdReq | wrEn);

  always_comb begin
    strb.load   = !running && startValid;
    strb.step   = running;
    strb.finish = running && (count == LAST);
    strb.wrHi   = !running && wrEn && wrSelHi;
    strb.wrLo   = !running && wrEn && !wrSelHi;
    strb.op     = mdu_op_e'(startOp);
  end

endmodule

// File: rtl/mdu_dpath.sv
module mdu_dpath
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdu_strobe_t       strb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSelHi,
  output logic [DATA_W-1:0] rdData
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   accHi;
  logic [DATA_W-1:0] accLo;
  logic [DATA_W-1:0] opnd;
  logic              isDiv;
  logic              negLo;
  logic              negHi;
  logic [DATA_W-1:0] hiReg;
  logic [DATA_W-1:0] loReg;

  // operand preparation
  logic              signedOp, aNeg, bNeg;
  logic [DATA_W-1:0] magA, magB;

  always_comb begin
    signedOp = (strb.op == OP_MULS) || (strb.op == OP_DIVS);
    aNeg     = signedOp && opA[DATA_W-1];
    bNeg     = signedOp && opB[DATA_W-1];
    magA     = aNeg ? (~opA + 1'b1) : opA;
    magB     = bNeg ? (~opB + 1'b1) : opB;
  end

  // one iteration of shift-add multiply or restoring divide
  logic [DATA_W:0]   mulSum;
  logic [DATA_W:0]   divShift;
  logic [DATA_W:0]   divTrial;
  logic              divFits;
  logic [DATA_W:0]   nextHi;
  logic [DATA_W-1:0] nextLo;

  always_comb begin
    mulSum   = {1'b0, accHi[DATA_W-1:0]} + (accLo[0] ? {1'b0, opnd} : '0);
    divShift = {accHi[DATA_W-1:0], accLo[DATA_W-1]};
    divTrial = divShift - {1'b0, opnd};
    divFits  = !divTrial[DATA_W];
    if (isDiv) begin
      nextHi = divFits ? divTrial : divShift;
      nextLo = {accLo[DATA_W-2:0], divFits};
    end else begin
      nextHi = {1'b0, mulSum[DATA_W:1]};
      nextLo = {mulSum[0], accLo[DATA_W-1:1]};
    end
  end

  // sign correction applied on the final iteration
  logic [PROD_W-1:0] rawProd, fixProd;
  logic [DATA_W-1:0] fixQuo, fixRem, finHi, finLo;

  always_comb begin
    rawProd = {nextHi[DATA_W-1:0], nextLo};
    fixProd = negLo ? (~rawProd + 1'b1) : rawProd;
    fixQuo  = negLo ? (~nextLo + 1'b1) : nextLo;
    fixRem  = negHi ? (~nextHi[DATA_W-1:0] + 1'b1) : nextHi[DATA_W-1:0];
    finHi   = isDiv ? fixRem : fixProd[PROD_W-1:DATA_W];
    finLo   = isDiv ? fixQuo : fixProd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHi <= '0;
      accLo <= '0;
      opnd  <= '0;
      isDiv <= 1'b0;
      negLo <= 1'b0;
      negHi <= 1'b0;
    end else if (strb.load) begin
      isDiv <= strb.op[1];
      accHi <= '0;
      negLo <= aNeg ^ bNeg;
      negHi <= strb.op[1] && aNeg;
      if (strb.op[1]) begin
        accLo <= magA;
        opnd  <= magB;
      end else begin
        accLo <= magB;
        opnd  <= magA;
      end
    end else if (strb.step) begin
      accHi <= nextHi;
      accLo <= nextLo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      loReg <= '0;
    end else if (strb.finish) begin
      hiReg <= finHi;
      loReg <= finLo;
    end else begin
      if (strb.wrHi) hiReg <= wrData;
      if (strb.wrLo) loReg <= wrData;
    end
  end

  assign rdData = rdSelHi ? hiReg : loReg;

endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [1:0]        startOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              busy,
  input  logic              rdReq,
  input  logic              rdSelHi,
  output logic [DATA_W-1:0] rdData,
  output logic              stall,
  input  logic              wrEn,
  input  logic              wrSelHi,
  input  logic [DATA_W-1:0] wrData
);
  mdu_strobe_t strb;

  mdu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .rdReq(rdReq), .wrEn(wrEn), .wrSelHi(wrSelHi),
    .busy(busy), .stall(stall), .strb(strb)
  );

  mdu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opA(opA), .opB(opB),
    .wrData(wrData), .rdSelHi(rdSelHi), .rdData(rdData)
  );

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startValid,
  input logic              busy,
  input logic              rdReq,
  input logic              stall,
  input logic              rdSelHi,
  input logic [DATA_W-1:0] rdData
);
  int unsigned runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else if (startValid && !busy) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
  end

  // R6: accepted start raises busy next cycle
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !busy) |=> busy);

  // R6: busy run lasts exactly DATA_W cycles
  a_r6_run_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == DATA_W));

  // R8: no stall while idle, stall on read request while busy
  a_r8_idle_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stall);
  a_r8_read_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdReq) |-> stall);

  // R9: HI/LO untouched mid-run (writes ignored while busy)
  a_r9_hold_in_run: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(rdSelHi)) |-> $stable(rdData));

endmodule

bind mdu_top mdu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .busy(busy),
  .rdReq(rdReq), .stall(stall), .rdSelHi(rdSelHi), .rdData(rdData)
);

// File: tb/sim_mdu_top.sv
module sim_mdu_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        startValid;
  logic [1:0]  startOp;
  logic [31:0] opA, opB;
  logic        busy;
  logic        rdReq, rdSelHi;
  logic [31:0] rdData;
  logic        stall;
  logic        wrEn, wrSelHi;
  logic [31:0] wrData;

  always #10 clk = ~clk;

  mdu_top u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .opA(opA), .opB(opB), .busy(busy), .rdReq(rdReq), .rdSelHi(rdSelHi),
    .rdData(rdData), .stall(stall), .wrEn(wrEn), .wrSelHi(wrSelHi),
    .wrData(wrData)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog: cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expMul(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    sa = $signed(a);
    sb = $signed(b);
    if (op == 2'd0) return 64'(sa * sb);
    return {32'b0, a} * {32'b0, b};
  endfunction

  // returns {remainder, quotient}
  function automatic logic [63:0] expDiv(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (op == 2'd2) begin
      sa = $signed(a);
      sb = $signed(b);
      q = sa / sb;
      r = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  task automatic readHL(output logic [31:0] hi, output logic [31:0] lo);
    rdSelHi = 1'b1; #1 hi = rdData;
    rdSelHi = 1'b0; #1 lo = rdData;
  endtask

  // runs one operation; checks busy timing (tTag) and optional probes
  task automatic runOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input string tTag, input bit inject, input bit probe,
                       output logic [31:0] hi, output logic [31:0] lo);
    int bad;
    logic [31:0] hiBefore;
    bad = 0;
    hiBefore = '0;
    @(negedge clk);
    startValid = 1'b1; startOp = op; opA = a; opB = b;
    @(negedge clk);
    startValid = 1'b0;
    chk({tTag, " busy rises"}, 32'(busy), 32'd1);
    for (int i = 1; i < 32; i++) begin
      if (inject && i == 5) begin
        startValid = 1'b1; startOp = 2'd3; opA = 32'd100; opB = 32'd7;
      end
      if (probe && i == 10) begin
        rdReq = 1'b1; rdSelHi = 1'b1;
        #1 chk("R8 stall on read while busy", 32'(stall), 32'd1);
        hiBefore = rdData;
        rdReq = 1'b0;
        wrEn = 1'b1; wrSelHi = 1'b1; wrData = ~hiBefore;
        #1 chk("R9 stall on write while busy", 32'(stall), 32'd1);
      end
      if (probe && i == 11) begin
        rdSelHi = 1'b1;
        #1 chk("R9 write while busy ignored", rdData, hiBefore);
      end
      @(negedge clk);
      startValid = 1'b0; wrEn = 1'b0; rdReq = 1'b0;
      if (busy !== 1'b1) bad++;
    end
    chk({tTag, " busy held 32 cycles"}, 32'(bad), 32'd0);
    @(negedge clk);
    chk({tTag, " busy falls after 32"}, 32'(busy), 32'd0);
    readHL(hi, lo);
  endtask

  task automatic checkOp(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] hi, lo;
    logic [63:0] e;
    string tag;
    runOp(op, a, b, "R6", 1'b0, 1'b0, hi, lo);
    case (op)
      2'd0: tag = "R2";
      2'd1: tag = "R3";
      2'd2: tag = "R4";
      default: tag = "R5";
    endcase
    e = op[1] ? expDiv(op, a, b) : expMul(op, a, b);
    chk({tag, " HI"}, hi, e[63:32]);
    chk({tag, " LO"}, lo, e[31:0]);
  endtask

  initial begin
    logic [31:0] hi, lo;
    logic [1:0]  rop;
    logic [31:0] ra, rb;
    rstN = 1'b0; startValid = 1'b0; startOp = '0; opA = '0; opB = '0;
    rdReq = 1'b0; rdSelHi = 1'b0; wrEn = 1'b0; wrSelHi = 1'b0; wrData = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 stall", 32'(stall), 32'd0);
    readHL(hi, lo);
    chk("R1 HI", hi, 32'd0);
    chk("R1 LO", lo, 32'd0);

    // R9 move-to while idle
    wrEn = 1'b1; wrSelHi = 1'b1; wrData = 32'hCAFE_0001;
    @(negedge clk);
    wrSelHi = 1'b0; wrData = 32'h1234_5678;
    @(negedge clk);
    wrEn = 1'b0;
    readHL(hi, lo);
    chk("R9 write HI", hi, 32'hCAFE_0001);
    chk("R9 write LO", lo, 32'h1234_5678);

    // R8 idle read: no stall, select works
    rdReq = 1'b1; rdSelHi = 1'b0;
    #1 chk("R8 idle no stall", 32'(stall), 32'd0);
    chk("R8 LO select", rdData, 32'h1234_5678);
    rdSelHi = 1'b1;
    #1 chk("R8 HI select", rdData, 32'hCAFE_0001);
    rdReq = 1'b0;

    // directed corners
    checkOp(2'd0, 32'h8000_0000, 32'hFFFF_FFFF);  // R2
    checkOp(2'd0, 32'hFFFF_FFF9, 32'd6);           // R2
    checkOp(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);  // R3
    checkOp(2'd2, 32'hFFFF_FFF9, 32'd2);           // R4 -7/2
    checkOp(2'd2, 32'd7, 32'hFFFF_FFFE);           // R4 7/-2
    checkOp(2'd2, 32'h8000_0000, 32'hFFFF_FFFF);  // R4 no overflow
    checkOp(2'd3, 32'hFFFF_FFFF, 32'd10);          // R5
    checkOp(2'd3, 32'd5, 32'd9);                   // R5

    // R10 divide by zero completes on time
    runOp(2'd3, 32'd77, 32'd0, "R10", 1'b0, 1'b0, hi, lo);
    runOp(2'd2, 32'hFFFF_0000, 32'd0, "R10", 1'b0, 1'b0, hi, lo);

    // R7 start while busy is ignored
    runOp(2'd1, 32'd3, 32'd4, "R7", 1'b1, 1'b0, hi, lo);
    chk("R7 HI unchanged by ignored start", hi, 32'd0);
    chk("R7 LO unchanged by ignored start", lo, 32'd12);

    // R8/R9 probes while busy, then result still correct
    runOp(2'd0, 32'd1000, 32'hFFFF_FFFD, "R6", 1'b0, 1'b1, hi, lo);
    chk("R2 HI after probes", hi, 32'hFFFF_FFFF);
    chk("R2 LO after probes", lo, 32'hFFFF_F448);

    // constrained random
    for (int n = 0; n < 40; n++) begin
      rop = 2'($urandom % 4);
      ra = $urandom;
      rb = $urandom;
      if ($urandom % 2) rb = (rb % 1000) + 1;
      if (rop[1] && rb == 32'd0) rb = 32'd1;
      checkOp(rop, ra, rb);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule